// File: doc/BRIEF.md
# Quadrature Index Qualifier and Reference Controller

This block sits between the synchronized encoder inputs and a set of position counters. For each counter channel it watches that channel's index line together with its two quadrature phases and turns the raw index into a qualified index event. An event exists only when the index is high while the phases sit in the state chosen by a shared 2-bit qualification code. The block does not count position. It only decides when a counter must be cleared and emits a one-clock clear pulse for that counter.

Clearing follows a referencing rule. The first two qualified events after reset always clear the counter, whatever its clear-enable bit says. The channel's referenced flag rises with the second of these forced clears, and from then on the counter is cleared by an index event only when its clear-enable bit is set. A re-arm strobe restarts the two-event forced sequence on every channel. When the counter array is configured as three separate counters there is no index function, so a mode input suppresses every clear pulse.

Top module: `idx_ref_unit`

## Requirements
- R1: A channel's index is qualified only while z is 1 and the phases match the code: code 0 needs a=1 b=1, code 1 needs a=1 b=0, code 2 needs a=0 b=1, code 3 needs a=0 b=0.
- R2: A clear pulse lasts one clock and appears on the clock after the first cycle in which the qualified index is seen. A qualified index held high for several cycles produces a single pulse.
- R3: After reset, the first two qualified events of a channel clear that channel even when its clear-enable bit is 0.
- R4: Once a channel is referenced, a qualified event clears it only if its clear-enable bit is 1.
- R5: Reset drives all clear pulses and all referenced flags to 0. A channel's referenced flag becomes 1 in the same cycle as its second forced clear pulse.
- R6: A re-arm strobe drops every referenced flag on the next clock and restarts the two-event forced sequence. A qualified event in the re-arm cycle itself counts as the first forced clear.
- R7: While the three-counter mode input is 1, no clear pulse is produced, and the suppressed events do not advance the forced sequence.
- R8: Channels are independent. Each uses its own a, b, z and clear-enable bit and keeps its own forced-clear progress.
- R9: An index pulse whose phases do not match the code produces no clear and does not advance the forced sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| a_in | input | NUM_CH | Synchronized phase A per channel |
| b_in | input | NUM_CH | Synchronized phase B per channel |
| z_in | input | NUM_CH | Synchronized index per channel |
| qual_code | input | 2 | Phase state required for a valid index |
| clr_en | input | NUM_CH | Per-channel clear-on-index enable, used after referencing |
| tri_mode | input | 1 | Three-counter configuration; suppresses all clears |
| rearm | input | 1 | Restart the forced-clear referencing sequence |
| clr_pulse | output | NUM_CH | One-clock clear request per channel |
| referenced | output | NUM_CH | Channel has seen its forced clears |

## Verification
The bench uses the default build of three channels with two forced clears. This lets it run the referencing sequence on each channel separately and drive coincident index events on channels whose enables differ. It also reaches the case where a re-arm and a qualified event land in the same cycle. With all four qualification codes swept against matching and mismatching phases, and with a suppressed event placed between the two forced clears, every branch of the clear decision is exercised.

// File: rtl/idx_ref_pkg.sv
package idx_ref_pkg;

    typedef enum logic [1:0] {
        QUAL_HI_HI = 2'b00,
        QUAL_HI_LO = 2'b01,
        QUAL_LO_HI = 2'b10,
        QUAL_LO_LO = 2'b11
    } qual_code_e;

    typedef struct packed {
        logic level;   // index qualified this cycle
        logic rise;    // first cycle of a qualified index
    } idx_evt_t;

    // Phase levels required by a code: bit 1 selects A, bit 0 selects B (inverted sense).
    function automatic logic qual_match(input qual_code_e code, input logic a,
                                        input logic b, input logic z);
        return z & (a == ~code[1]) & (b == ~code[0]);
    endfunction

endpackage

// File: rtl/idx_qualifier.sv
module idx_qualifier
    import idx_ref_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       a,
    input  logic       b,
    input  logic       z,
    input  qual_code_e code,
    output idx_evt_t   evt
);
    logic level_prev_q;

    always_comb begin
        evt.level = qual_match(code, a, b, z);
        evt.rise  = evt.level & ~level_prev_q;
    end

    always_ff @(posedge clk) begin
        if (rst) level_prev_q <= 1'b0;
        else     level_prev_q <= evt.level;
    end
endmodule

// File: rtl/idx_ref_tracker.sv
module idx_ref_tracker #(
    parameter int FORCED = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic clr_en,
    input  logic suppress,
    input  logic rearm,
    output logic clr_pulse,
    output logic referenced
);
    localparam int CW = $clog2(FORCED + 1);
    localparam logic [CW-1:0] LIMIT = CW'(FORCED);

    logic [CW-1:0] seen_q, seen_eff, seen_d;
    logic          forcing, fire, pulse_q;

    always_comb begin
        seen_eff = rearm ? '0 : seen_q;
        forcing  = (seen_eff < LIMIT);
        fire     = rise & ~suppress & (forcing | clr_en);
        seen_d   = (fire && forcing) ? CW'(seen_eff + 1'b1) : seen_eff;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            seen_q  <= seen_d;
            pulse_q <= fire;
        end
    end

    assign clr_pulse  = pulse_q;
    assign referenced = (seen_q == LIMIT);
endmodule

// File: rtl/idx_ref_unit.sv
module idx_ref_unit
    import idx_ref_pkg::*;
#(
    parameter int NUM_CH = 3,
    parameter int FORCED = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] a_in,
    input  logic [NUM_CH-1:0] b_in,
    input  logic [NUM_CH-1:0] z_in,
    input  logic [1:0]        qual_code,
    input  logic [NUM_CH-1:0] clr_en,
    input  logic              tri_mode,
    input  logic              rearm,
    output logic [NUM_CH-1:0] clr_pulse,
    output logic [NUM_CH-1:0] referenced
);
    qual_code_e code;
    assign code = qual_code_e'(qual_code);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        idx_evt_t evt;

        idx_qualifier u_qual (
            .clk  (clk),
            .rst  (rst),
            .a    (a_in[ch]),
            .b    (b_in[ch]),
            .z    (z_in[ch]),
            .code (code),
            .evt  (evt)
        );

        idx_ref_tracker #(.FORCED(FORCED)) u_trk (
            .clk        (clk),
            .rst        (rst),
            .rise       (evt.rise),
            .clr_en     (clr_en[ch]),
            .suppress   (tri_mode),
            .rearm      (rearm),
            .clr_pulse  (clr_pulse[ch]),
            .referenced (referenced[ch])
        );
    end
endmodule

// File: rtl/idx_ref_unit_chk.sv
module idx_ref_unit_chk #(
    parameter int NUM_CH = 3
) (
    input logic              clk,
    input logic              rst,
    input logic [NUM_CH-1:0] z_in,
    input logic [NUM_CH-1:0] clr_en,
    input logic              tri_mode,
    input logic              rearm,
    input logic [NUM_CH-1:0] clr_pulse,
    input logic [NUM_CH-1:0] referenced
);
    // R5: reset clears status
    a_r5_reset_state: assert property (@(posedge clk)
        rst |=> (referenced == '0 && clr_pulse == '0));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_a
        // R1: a clear needs an index high on the previous cycle
        a_r1_needs_index: assert property (@(posedge clk) disable iff (rst)
            clr_pulse[i] |-> $past(z_in[i]));
        // R2: pulses never last two cycles
        a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
            clr_pulse[i] |=> !clr_pulse[i]);
        // R4: referenced and disabled means no clear
        a_r4_gated: assert property (@(posedge clk) disable iff (rst)
            (referenced[i] && !rearm && !clr_en[i]) |=> !clr_pulse[i]);
        // R6: referenced drops only through re-arm or reset
        a_r6_drop_cause: assert property (@(posedge clk) disable iff (rst)
            $fell(referenced[i]) |-> ($past(rearm) || $past(rst)));
        // R7: three-counter mode blocks clears
        a_r7_suppress: assert property (@(posedge clk) disable iff (rst)
            tri_mode |=> !clr_pulse[i]);
    end
endmodule

bind idx_ref_unit idx_ref_unit_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .z_in       (z_in),
    .clr_en     (clr_en),
    .tri_mode   (tri_mode),
    .rearm      (rearm),
    .clr_pulse  (clr_pulse),
    .referenced (referenced)
);

// File: tb/idx_ref_unit_bench.sv
module idx_ref_unit_bench;
    localparam int NCH = 3;

    typedef struct {
        logic [NCH-1:0] pulse;
        logic [NCH-1:0] refd;
        string          tag;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] a_in = '0, b_in = '0, z_in = '0, clr_en = '0;
    logic [1:0]     qual_code = 2'b00;
    logic           tri_mode = 1'b0, rearm = 1'b0;
    logic [NCH-1:0] clr_pulse, referenced;

    int   n_cmp = 0, n_bad = 0;
    bit   done = 0;
    exp_t q[$];

    logic m_prev[NCH];
    int   m_cnt[NCH];

    always #4 clk = ~clk;

    idx_ref_unit u_idx_ref_unit (
        .clk(clk), .rst(rst), .a_in(a_in), .b_in(b_in), .z_in(z_in),
        .qual_code(qual_code), .clr_en(clr_en), .tri_mode(tri_mode),
        .rearm(rearm), .clr_pulse(clr_pulse), .referenced(referenced)
    );

    // Driver: called at a falling edge, applies inputs, predicts, waits one cycle.
    task automatic step(input logic [NCH-1:0] a, input logic [NCH-1:0] b,
                        input logic [NCH-1:0] z, input logic rr, input string tag);
        exp_t e;
        a_in = a; b_in = b; z_in = z; rearm = rr;
        e.tag = tag;
        for (int i = 0; i < NCH; i++) begin
            logic lvl, rise, fire;
            int   eff;
            // R1 code table
            case (qual_code)
                2'd0: lvl = z[i] & a[i] & b[i];
                2'd1: lvl = z[i] & a[i] & ~b[i];
                2'd2: lvl = z[i] & ~a[i] & b[i];
                default: lvl = z[i] & ~a[i] & ~b[i];
            endcase
            rise = lvl & ~m_prev[i];
            m_prev[i] = lvl;
            eff  = rr ? 0 : m_cnt[i];
            fire = rise & ~tri_mode & ((eff < 2) | clr_en[i]);
            if (fire && eff < 2) eff++;
            m_cnt[i] = eff;
            e.pulse[i] = fire;
            e.refd[i]  = (eff == 2);
        end
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic zpulse(input int ch, input logic a, input logic b, input string tag);
        logic [NCH-1:0] av, bv, zv;
        av = '0; bv = '0; zv = '0;
        av[ch] = a; bv[ch] = b; zv[ch] = 1'b1;
        step(av, bv, zv, 1'b0, tag);
        zv[ch] = 1'b0;
        step(av, bv, zv, 1'b0, tag);
    endtask

    // Monitor: compares one expected item per cycle after the rising edge.
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (clr_pulse !== e.pulse || referenced !== e.refd) begin
                n_bad++;
                $display("FAIL %s: pulse=%b ref=%b expected pulse=%b ref=%b",
                         e.tag, clr_pulse, referenced, e.pulse, e.refd);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NCH; i++) begin m_prev[i] = 0; m_cnt[i] = 0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_cmp++;
        if (clr_pulse !== '0 || referenced !== '0) begin
            n_bad++;
            $display("FAIL R5 reset: pulse=%b ref=%b expected pulse=000 ref=000",
                     clr_pulse, referenced);
        end

        // R3/R5: two forced clears on channel 0 with enable low
        zpulse(0, 1, 1, "R3");
        zpulse(0, 1, 1, "R5");
        zpulse(0, 1, 1, "R4");        // referenced, disabled: no clear
        clr_en[0] = 1'b1;
        zpulse(0, 1, 1, "R4");        // enabled: clear
        // R9: mismatched phases on channel 1
        zpulse(1, 0, 1, "R9");
        zpulse(1, 1, 1, "R9");
        zpulse(1, 1, 1, "R9");
        // R2: held index on channel 2
        step(3'b100, 3'b100, 3'b100, 0, "R2");
        step(3'b100, 3'b100, 3'b100, 0, "R2");
        step(3'b100, 3'b100, 3'b100, 0, "R2");
        step(3'b100, 3'b100, 3'b000, 0, "R2");
        // R1: all codes, matching and mismatching phases
        clr_en = 3'b011;
        for (int c = 0; c < 4; c++) begin
            qual_code = 2'(c);
            zpulse(0, ~qual_code[1], ~qual_code[0], "R1");
            zpulse(0, qual_code[1], ~qual_code[0], "R1");
            zpulse(0, ~qual_code[1], qual_code[0], "R1");
        end
        qual_code = 2'b00;
        // R6: re-arm alone, then forced clears again
        clr_en = 3'b000;
        step('0, '0, '0, 1, "R6");
        zpulse(0, 1, 1, "R6");
        zpulse(0, 1, 1, "R6");
        zpulse(0, 1, 1, "R6");
        // R6: re-arm coinciding with an event on channel 1
        zpulse(1, 1, 1, "R6");
        zpulse(1, 1, 1, "R6");
        step(3'b010, 3'b010, 3'b010, 1, "R6");
        step(3'b010, 3'b010, 3'b000, 0, "R6");
        zpulse(1, 1, 1, "R6");
        zpulse(1, 1, 1, "R6");
        // R7: suppression does not advance the sequence (channel 2 needs one more)
        step('0, '0, '0, 1, "R7");
        zpulse(2, 1, 1, "R7");
        tri_mode = 1'b1;
        zpulse(2, 1, 1, "R7");
        zpulse(0, 1, 1, "R7");
        tri_mode = 1'b0;
        zpulse(2, 1, 1, "R7");
        // R8: coincident events, different enables
        clr_en = 3'b001;
        step(3'b111, 3'b111, 3'b111, 0, "R8");
        step(3'b111, 3'b111, 3'b000, 0, "R8");
        step(3'b111, 3'b111, 3'b111, 0, "R8");
        step(3'b111, 3'b111, 3'b000, 0, "R8");
        repeat (3) @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule